// File: doc/BRIEF.md
# Converter Fault Protection Sequencer

This block decides, one clock at a time, whether the PWM of a switch-mode power converter may run. It takes a strobe for each switching cycle, two flags that say why that cycle ended (peak current or maximum duty), a supply-clamp over-current level and a junction over-temperature level. From these it detects four fault kinds. Any fault stops switching for a fixed restart time. Switching then comes back through a stepped soft start that raises the current-limit setpoint in eight steps.

Over-temperature is handled differently from the other faults. After each restart time the block grants exactly one test switching cycle and reads the temperature flag at the end of that cycle. If the flag is still set, it waits another restart time. If the flag is clear, it soft-starts. All durations come from a millisecond tick, which is the system clock divided by a prescaler parameter. A static input selects which of two overload end-counts applies. A 2-bit code keeps the cause of the most recent trip.

Top module: `fps_sequencer`

## Requirements
- R1: After reset the block is in soft start with `pwm_en`=1, `ss_step`=0, `test_cyc_req`=0 and `trip_cause`=0.
- R2: An overload counter rises on each strobe that has `oc_end`=1. It falls on each strobe with `oc_end`=0 and stops at zero. The strobe that brings it to `OVL_CYC_LO` trips with `trip_cause`=0 (overload).
- R3: With `freq_hi`=1 the overload end-count is `OVL_CYC_HI` instead of `OVL_CYC_LO`.
- R4: After any trip, `pwm_en` is 0 for exactly `RESTART_TICKS`*`TICK_CYCLES` clocks. This holds even if the fault clears during that time.
- R5: In soft start, `ss_step` takes the values 0 to 7, one value per `TICK_CYCLES` clocks, and the block then enters run, where `ss_step`=7. Soft start follows reset and every restart that ends without a failed test cycle.
- R6: `DMAX_CYC` strobes in a row with `dmax_end`=1 cause a trip with `trip_cause`=1. Any strobe with `dmax_end`=0 clears the run of consecutive strobes.
- R7: In run, `clamp_oc` held high for more than `CLAMP_TICKS`*`TICK_CYCLES` clocks causes a trip with `trip_cause`=2. A clamp level during soft start is ignored.
- R8: `over_temp` causes an immediate trip with `trip_cause`=3. After that restart the block grants a test cycle: `pwm_en`=1 and `test_cyc_req`=1 until the next strobe. If `over_temp` is high at that strobe, a new restart begins. Otherwise soft start begins.
- R9: When several faults occur in the same clock, the recorded cause follows the priority thermal, then clamp, then overload, then max duty.
- R10: Fault inputs are ignored while the restart time runs. The overload and max-duty counts start from zero on every soft start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cyc_stb | input | 1 | One-clock pulse at the end of each switching cycle |
| oc_end | input | 1 | Cycle ended by the overcurrent comparator (valid with strobe) |
| dmax_end | input | 1 | Cycle ended by maximum duty (valid with strobe) |
| clamp_oc | input | 1 | Supply clamp over-current level |
| over_temp | input | 1 | Junction over-temperature level |
| freq_hi | input | 1 | Static: 1 selects the high-frequency overload end-count |
| pwm_en | output | 1 | PWM may switch |
| test_cyc_req | output | 1 | A single thermal test cycle is granted |
| ss_step | output | STEP_W (3) | Current-limit step: 0..7 in soft start, 7 in run |
| trip_cause | output | 2 | Last trip: 0 overload, 1 max duty, 2 clamp, 3 thermal |

## Verification
The properties take for granted that `cyc_stb` is a single-clock pulse and that the two cycle-end flags matter only in the clock that carries the strobe. They also assume `freq_hi` stays constant outside reset, so that the overload bound the counter is compared with never moves under it. The stimulus drives every strobe for exactly one clock with at least one idle clock after it. It changes `freq_hi` only while reset is held, and it changes levels on the falling clock edge.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [1:0] {
    ST_SOFT = 2'd0,
    ST_RUN  = 2'd1,
    ST_REST = 2'd2,
    ST_TEST = 2'd3
  } fps_state_e;

  typedef enum logic [1:0] {
    CAUSE_OVL   = 2'd0,
    CAUSE_DMAX  = 2'd1,
    CAUSE_CLAMP = 2'd2,
    CAUSE_THERM = 2'd3
  } fps_cause_e;

  // overload end-count chosen by the static frequency option
  function automatic int unsigned ovl_limit(int unsigned lo, int unsigned hi, logic sel);
    return sel ? hi : lo;
  endfunction

  // fixed priority among simultaneous faults
  function automatic fps_cause_e pick_cause(logic therm, logic clamp, logic ovl);
    if (therm)      return CAUSE_THERM;
    else if (clamp) return CAUSE_CLAMP;
    else if (ovl)   return CAUSE_OVL;
    else            return CAUSE_DMAX;
  endfunction

endpackage

// File: rtl/fps_tick.sv
module fps_tick #(
  parameter int unsigned TICK_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = $clog2(TICK_CYCLES + 1);
  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(TICK_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fps_ovl.sv
module fps_ovl #(
  parameter int unsigned LIM_LO = 3000,
  parameter int unsigned LIM_HI = 6000,
  localparam int unsigned W = $clog2(LIM_HI + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         stb,
  input  logic         oc,
  input  logic         freq_hi,
  output logic         trip,
  output logic [W-1:0] cnt,
  output logic [W-1:0] lim
);
  assign lim  = W'(fps_pkg::ovl_limit(LIM_LO, LIM_HI, freq_hi));
  assign trip = en && stb && oc && (cnt == lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en)        cnt <= '0;
    else if (stb) begin
      if (oc) begin
        if (cnt != lim)  cnt <= cnt + 1'b1;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/fps_dmax.sv
module fps_dmax #(
  parameter int unsigned LIM = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic stb,
  input  logic dm,
  output logic trip
);
  localparam int unsigned W = $clog2(LIM + 1);
  logic [W-1:0] run_cnt;

  assign trip = en && stb && dm && (run_cnt == W'(LIM - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_cnt <= '0;
    else if (!en)      run_cnt <= '0;
    else if (stb) begin
      if (!dm)                       run_cnt <= '0;
      else if (run_cnt != W'(LIM))   run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fps_clamp.sv
module fps_clamp #(
  parameter int unsigned LIM_CLKS = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clamp,
  output logic trip
);
  localparam int unsigned W = $clog2(LIM_CLKS + 1);
  logic [W-1:0] hold;

  // trips on the first clock past the allowed continuous window
  assign trip = en && clamp && (hold == W'(LIM_CLKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   hold <= '0;
    else if (!en || !clamp)       hold <= '0;
    else if (hold != W'(LIM_CLKS)) hold <= hold + 1'b1;
  end
endmodule

// File: rtl/fps_sequencer.sv
module fps_sequencer #(
  parameter int unsigned TICK_CYCLES   = 1000,
  parameter int unsigned RESTART_TICKS = 1000,
  parameter int unsigned CLAMP_TICKS   = 5,
  parameter int unsigned OVL_CYC_LO    = 3000,
  parameter int unsigned OVL_CYC_HI    = 6000,
  parameter int unsigned DMAX_CYC      = 10,
  parameter int unsigned SS_STEPS      = 8,
  localparam int unsigned STEP_W       = $clog2(SS_STEPS),
  localparam int unsigned OVL_W        = $clog2(OVL_CYC_HI + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_stb,
  input  logic              oc_end,
  input  logic              dmax_end,
  input  logic              clamp_oc,
  input  logic              over_temp,
  input  logic              freq_hi,
  output logic              pwm_en,
  output logic              test_cyc_req,
  output logic [STEP_W-1:0] ss_step,
  output logic [1:0]        trip_cause
);
  import fps_pkg::*;

  localparam int unsigned RW        = $clog2(RESTART_TICKS + 1);
  localparam int unsigned CLAMP_CLK = CLAMP_TICKS * TICK_CYCLES;
  localparam logic [STEP_W-1:0] STEP_TOP = STEP_W'(SS_STEPS - 1);

  fps_state_e        st, st_nxt;
  fps_cause_e        cause;
  logic [STEP_W-1:0] step;
  logic [RW-1:0]     rcnt;
  logic              tick, mon_en, run_en;
  logic              ovl_trip, dmax_trip, clamp_trip, therm_trip;
  logic              trip_any, test_fail, restart_done;
  logic [OVL_W-1:0]  ovl_cnt, ovl_lim;

  assign mon_en = (st == ST_SOFT) || (st == ST_RUN);
  assign run_en = (st == ST_RUN);

  fps_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(st_nxt != st), .tick(tick)
  );

  fps_ovl #(.LIM_LO(OVL_CYC_LO), .LIM_HI(OVL_CYC_HI)) u_ovl (
    .clk(clk), .rst_n(rst_n), .en(mon_en), .stb(cyc_stb), .oc(oc_end),
    .freq_hi(freq_hi), .trip(ovl_trip), .cnt(ovl_cnt), .lim(ovl_lim)
  );

  fps_dmax #(.LIM(DMAX_CYC)) u_dmax (
    .clk(clk), .rst_n(rst_n), .en(mon_en), .stb(cyc_stb), .dm(dmax_end),
    .trip(dmax_trip)
  );

  fps_clamp #(.LIM_CLKS(CLAMP_CLK)) u_clamp (
    .clk(clk), .rst_n(rst_n), .en(run_en), .clamp(clamp_oc), .trip(clamp_trip)
  );

  assign therm_trip   = mon_en && over_temp;
  assign trip_any     = ovl_trip || dmax_trip || clamp_trip || therm_trip;
  assign test_fail    = (st == ST_TEST) && cyc_stb && over_temp;
  assign restart_done = (st == ST_REST) && tick && (rcnt == RW'(RESTART_TICKS - 1));

  always_comb begin
    st_nxt = st;
    case (st)
      ST_SOFT: begin
        if (trip_any)                     st_nxt = ST_REST;
        else if (tick && step == STEP_TOP) st_nxt = ST_RUN;
      end
      ST_RUN:  if (trip_any) st_nxt = ST_REST;
      ST_REST: if (restart_done) st_nxt = (cause == CAUSE_THERM) ? ST_TEST : ST_SOFT;
      ST_TEST: if (cyc_stb) st_nxt = over_temp ? ST_REST : ST_SOFT;
      default: st_nxt = ST_SOFT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_SOFT;
      step  <= '0;
      rcnt  <= '0;
      cause <= CAUSE_OVL;
    end else begin
      st <= st_nxt;
      if (st_nxt == ST_SOFT && st != ST_SOFT) step <= '0;
      else if (st == ST_SOFT && tick && step != STEP_TOP) step <= step + 1'b1;
      if (st_nxt != st)              rcnt <= '0;
      else if (st == ST_REST && tick) rcnt <= rcnt + 1'b1;
      if (mon_en && trip_any)
        cause <= pick_cause(therm_trip, clamp_trip, ovl_trip);
      else if (test_fail)
        cause <= CAUSE_THERM;
    end
  end

  assign pwm_en       = (st != ST_REST);
  assign test_cyc_req = (st == ST_TEST);
  assign trip_cause   = cause;
  always_comb begin
    case (st)
      ST_RUN:  ss_step = STEP_TOP;
      ST_SOFT: ss_step = step;
      default: ss_step = '0;
    endcase
  end
endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
  parameter int unsigned STEP_W = 3,
  parameter int unsigned OVL_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dmax_end,
  input logic              clamp_oc,
  input logic              pwm_en,
  input logic              test_cyc_req,
  input logic [STEP_W-1:0] ss_step,
  input logic [1:0]        trip_cause,
  input logic              trip_any,
  input logic              test_fail,
  input logic              restart_done,
  input logic              dmax_trip,
  input logic              clamp_trip,
  input logic [OVL_W-1:0]  ovl_cnt,
  input logic [OVL_W-1:0]  ovl_lim
);
  assert_trip_stops_pwm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trip_any |=> !pwm_en);

  assert_resume_after_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_en) |-> $past(restart_done));

  assert_ovl_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_cnt <= ovl_lim);

  assert_step_climb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && $past(pwm_en)) |->
      ((ss_step == $past(ss_step)) || (ss_step == STEP_W'($past(ss_step) + 1'b1))));

  assert_dmax_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dmax_trip |-> dmax_end);

  assert_clamp_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_trip |-> ($past(clamp_oc) && ss_step == {STEP_W{1'b1}}));

  assert_test_grants_pwm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    test_cyc_req |-> (pwm_en && ss_step == '0));

  assert_test_fail_thermal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    test_fail |=> (!pwm_en && trip_cause == 2'd3));
endmodule

bind fps_sequencer fps_checker #(.STEP_W(STEP_W), .OVL_W(OVL_W)) u_fps_checker (
  .clk(clk), .rst_n(rst_n), .dmax_end(dmax_end), .clamp_oc(clamp_oc),
  .pwm_en(pwm_en), .test_cyc_req(test_cyc_req), .ss_step(ss_step),
  .trip_cause(trip_cause), .trip_any(trip_any), .test_fail(test_fail),
  .restart_done(restart_done), .dmax_trip(dmax_trip), .clamp_trip(clamp_trip),
  .ovl_cnt(ovl_cnt), .ovl_lim(ovl_lim)
);

// File: tb/test_fps_sequencer.sv
module test_fps_sequencer;
  localparam int TICK = 4;
  localparam int RT   = 6;
  localparam int CT   = 5;
  localparam int OLO  = 12;
  localparam int OHI  = 24;
  localparam int DMX  = 10;
  localparam int REST_CLK  = RT * TICK;
  localparam int CLAMP_CLK = CT * TICK;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_stb = 0, oc_end = 0, dmax_end = 0, clamp_oc = 0, over_temp = 0, freq_hi = 0;
  logic pwm_en, test_cyc_req;
  logic [2:0] ss_step;
  logic [1:0] trip_cause;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  fps_sequencer #(
    .TICK_CYCLES(TICK), .RESTART_TICKS(RT), .CLAMP_TICKS(CT),
    .OVL_CYC_LO(OLO), .OVL_CYC_HI(OHI), .DMAX_CYC(DMX), .SS_STEPS(8)
  ) i_fps_sequencer (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .oc_end(oc_end),
    .dmax_end(dmax_end), .clamp_oc(clamp_oc), .over_temp(over_temp),
    .freq_hi(freq_hi), .pwm_en(pwm_en), .test_cyc_req(test_cyc_req),
    .ss_step(ss_step), .trip_cause(trip_cause)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic negs(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input logic hi);
    @(negedge clk);
    rst_n = 0; cyc_stb = 0; oc_end = 0; dmax_end = 0; clamp_oc = 0; over_temp = 0;
    freq_hi = hi;
    negs(3);
    rst_n = 1;
  endtask

  task automatic strobe(input logic oc, input logic dm);
    @(negedge clk);
    cyc_stb = 1; oc_end = oc; dmax_end = dm;
    @(negedge clk);
    cyc_stb = 0; oc_end = 0; dmax_end = 0;
  endtask

  task automatic strobes(input int n, input logic oc, input logic dm);
    for (int i = 0; i < n; i++) strobe(oc, dm);
  endtask

  // called half a clock after the tripping edge
  task automatic restart_window(input string req);
    chk(req, "pwm_en right after trip", pwm_en, 0);
    negs(REST_CLK - 1);
    chk("R4", "pwm_en at last restart clock", pwm_en, 0);
    negs(1);
    chk("R4", "pwm_en after restart", pwm_en, 1);
    chk("R5", "ss_step at restart soft start", ss_step, 0);
  endtask

  task automatic t_reset;
    do_reset(0);
    #1;
    chk("R1", "pwm_en", pwm_en, 1);
    chk("R1", "ss_step", ss_step, 0);
    chk("R1", "test_cyc_req", test_cyc_req, 0);
    chk("R1", "trip_cause", trip_cause, 0);
    for (int k = 1; k < 8; k++) begin
      negs(TICK);
      chk("R5", $sformatf("ss_step step %0d", k), ss_step, k);
    end
    negs(TICK);
    chk("R5", "ss_step in run", ss_step, 7);
    chk("R5", "pwm_en in run", pwm_en, 1);
  endtask

  task automatic t_overload_lo;
    do_reset(0);
    strobes(5, 0, 0);
    strobes(OLO - 1, 1, 0);
    chk("R2", "no trip below count", pwm_en, 1);
    strobe(0, 0);
    strobe(1, 0);
    chk("R2", "down-count respected", pwm_en, 1);
    strobe(1, 0);
    chk("R2", "trip cause overload", trip_cause, 0);
    restart_window("R2");
  endtask

  task automatic t_overload_hi;
    do_reset(1);
    strobes(OHI - 1, 1, 0);
    chk("R3", "no trip at low count with freq_hi", pwm_en, 1);
    strobe(1, 0);
    chk("R3", "trip at high count", pwm_en, 0);
  endtask

  task automatic t_dmax;
    do_reset(0);
    strobes(DMX - 1, 0, 1);
    strobe(0, 0);
    strobes(DMX - 1, 0, 1);
    chk("R6", "run broken, no trip", pwm_en, 1);
    strobe(0, 1);
    chk("R6", "trip cause max duty", trip_cause, 1);
    restart_window("R6");
  endtask

  task automatic t_clamp;
    do_reset(0);
    clamp_oc = 1;
    negs(30);
    chk("R7", "clamp ignored in soft start", pwm_en, 1);
    clamp_oc = 0;
    negs(6);
    chk("R7", "reached run", ss_step, 7);
    clamp_oc = 1;
    negs(CLAMP_CLK);
    clamp_oc = 0;
    chk("R7", "clamp at limit does not trip", pwm_en, 1);
    negs(2);
    clamp_oc = 1;
    negs(CLAMP_CLK + 1);
    clamp_oc = 0;
    chk("R7", "clamp trip cause", trip_cause, 2);
    restart_window("R7");
  endtask

  task automatic t_thermal;
    do_reset(0);
    negs(34);
    over_temp = 1;
    negs(1);
    chk("R8", "thermal trip pwm", pwm_en, 0);
    chk("R8", "thermal cause", trip_cause, 3);
    negs(REST_CLK);
    chk("R8", "test cycle pwm", pwm_en, 1);
    chk("R8", "test cycle request", test_cyc_req, 1);
    strobe(0, 0);
    chk("R8", "hot test cycle re-trips", pwm_en, 0);
    chk("R8", "request dropped", test_cyc_req, 0);
    negs(5);
    over_temp = 0;
    negs(REST_CLK - 6);
    chk("R4", "restart runs out after clear", pwm_en, 0);
    negs(1);
    chk("R8", "second test cycle", test_cyc_req, 1);
    strobe(0, 0);
    chk("R8", "cool test leads to soft start", test_cyc_req, 0);
    chk("R8", "soft start step", ss_step, 0);
    chk("R8", "pwm after cool test", pwm_en, 1);
    negs(TICK);
    chk("R5", "soft start after thermal", ss_step, 1);
  endtask

  task automatic t_priority;
    do_reset(0);
    strobes(OLO - 1, 1, 0);
    @(negedge clk);
    cyc_stb = 1; oc_end = 1; over_temp = 1;
    @(negedge clk);
    cyc_stb = 0; oc_end = 0; over_temp = 0;
    chk("R9", "thermal wins over overload", trip_cause, 3);
    chk("R9", "trip taken", pwm_en, 0);
  endtask

  task automatic t_ignore;
    do_reset(0);
    strobes(DMX, 0, 1);
    chk("R10", "dmax trip", pwm_en, 0);
    strobes(10, 1, 0);
    chk("R10", "cause kept during restart", trip_cause, 1);
    chk("R10", "still in restart", pwm_en, 0);
    negs(4);
    chk("R10", "restart ended", pwm_en, 1);
    strobes(OLO - 1, 1, 0);
    chk("R10", "overload count started at zero", pwm_en, 1);
    strobe(1, 0);
    chk("R10", "overload trip after fresh count", trip_cause, 0);
  endtask

  initial begin
    t_reset();
    t_overload_lo();
    t_overload_hi();
    t_dmax();
    t_clamp();
    t_thermal();
    t_priority();
    t_ignore();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule